// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block measures how long a newly enabled oscillator is left to settle before the rest of the chip relies on it. Software picks which oscillator to count (fast or slow), a prescale ratio, and an 8-bit warm-up length. It then turns the oscillator-enable bit on. From that moment the block counts rising edges of the chosen oscillator, divides them by the prescale ratio, and compares the result against the warm-up length scaled by a fixed power of two. When the count is reached, it sets a stable flag and emits a single-cycle completion interrupt.

Both oscillator inputs are sampled in the system clock domain through synchronizer chains, and their rising edges are detected there. Each oscillator must therefore run at less than half the system clock rate. One prescaled tick is `D` selected-source edges. One warm-up unit is `2**UNIT_SHIFT` prescaled ticks (default `UNIT_SHIFT = 2`). A full warm-up therefore lasts `D * (length << UNIT_SHIFT)` source edges. Writing the enable bit to 1 while it is already 1 leaves a running or finished warm-up untouched. Writing it to 0 abandons the warm-up.

Top module: `osc_warmup_timer`

## Requirements
- R1: After reset `osc_stable` and `warm_irq` are 0, the enable bit is 0, the control value is 0 (fast source, divide by 8) and the warm-up length is 0.
- R2: A write with `en_we` and `wdata[0]`=1 while the enable bit is 0 starts a warm-up, with the prescaler and the tick counter beginning from zero.
- R3: Control bit `wdata[0]` (written with `ctrl_we`) selects the counted source: 0 selects `hf_osc` and 1 selects `lf_osc`. Edges on the unselected source have no effect on the count.
- R4: Control bits `wdata[2:1]` select the prescale divisor D: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1.
- R5: With length L written through `data_we`, `osc_stable` stays 0 after `D*(L<<UNIT_SHIFT)-1` selected source edges and is 1 after `D*(L<<UNIT_SHIFT)` edges, rising on the 4th clock edge after the last source edge is first sampled high.
- R6: `warm_irq` is high for exactly one clock cycle per completed warm-up, in the same cycle that `osc_stable` rises.
- R7: Writing the enable bit to 1 while it is already 1 neither restarts a warm-up in progress nor clears `osc_stable`, and it raises no further interrupt.
- R8: Writing the enable bit to 0 aborts any warm-up, clears `osc_stable` and discards the partial count. A later enable needs the full edge count again.
- R9: With length 0, a warm-up completes on the second clock edge after the enabling write, with no source edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hf_osc | input | 1 | Fast oscillator output, sampled asynchronously |
| lf_osc | input | 1 | Slow oscillator output, sampled asynchronously |
| ctrl_we | input | 1 | Write strobe for source select and divisor |
| data_we | input | 1 | Write strobe for the warm-up length |
| en_we | input | 1 | Write strobe for the oscillator-enable bit |
| wdata | input | 8 | Write data shared by the three strobes |
| warm_irq | output | 1 | One-cycle completion interrupt |
| osc_stable | output | 1 | High once the warm-up has completed |

## Verification
A source edge driven on a falling clock edge passes through two synchronizer flops and one edge-detect stage. It moves the tick counter on the third rising edge, and stable and interrupt appear on the fourth. Each scenario therefore holds a generated source pulse high for three clock cycles and low for three more before it looks at the outputs. This lets the last edge's effect settle, so the check before that edge and the check after it are both exact. Writes complete one rising edge after the strobe, and the zero-length case is checked two falling edges after the enabling write. Interrupt pulses are counted on every rising edge and compared per scenario, so a missing pulse or an extra one both show up.

// File: rtl/owt_pkg.sv
package owt_pkg;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 2;
    localparam int PRE_W  = (2 ** DIV_W) - 1;

    typedef enum logic {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } src_sel_e;

    // divisor is 2**(PRE_W - sel); return divisor minus one
    function automatic logic [PRE_W-1:0] pre_limit(input logic [DIV_W-1:0] sel);
        logic [PRE_W:0] full;
        full = ({{PRE_W{1'b0}}, 1'b1} << PRE_W) >> sel;
        return PRE_W'(full - 1'b1);
    endfunction
endpackage

// File: rtl/owt_edge_sync.sv
module owt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R5
endmodule

// File: rtl/owt_prescaler.sv
module owt_prescaler
    import owt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [DIV_W-1:0] ratio_sel,
    output logic             tick_out
);
    logic [PRE_W-1:0] pcnt_q, pcnt_d;
    logic [PRE_W-1:0] limit;

    always_comb begin
        limit    = pre_limit(ratio_sel);
        tick_out = tick_in && (pcnt_q >= limit) && !clr;
        pcnt_d   = pcnt_q;
        if (clr)           pcnt_d = '0;
        else if (tick_out) pcnt_d = '0;
        else if (tick_in)  pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pcnt_q == '0); // R2
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick_in) |=> $stable(pcnt_q)); // R4
endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
    import owt_pkg::*;
#(
    parameter int UNIT_SHIFT  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hf_osc,
    input  logic              lf_osc,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic              en_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              warm_irq,
    output logic              osc_stable
);
    localparam int CNT_W = DATA_W + UNIT_SHIFT;

    typedef struct packed {
        logic              en;
        src_sel_e          src;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] len;
        logic              running;
        logic              stable;
        logic              irq;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t st_q, st_d;

    logic [1:0] osc_raw;
    logic [1:0] osc_rise;
    logic       src_rise;
    logic       pre_tick;
    logic       start;
    logic       stop;
    logic [CNT_W-1:0] target;

    assign osc_raw = {lf_osc, hf_osc};

    for (genvar gi = 0; gi < 2; gi++) begin : g_sync
        owt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (osc_raw[gi]),
            .rise     (osc_rise[gi])
        );
    end

    assign src_rise = osc_rise[st_q.src];
    assign start    = en_we && wdata[0] && !st_q.en;
    assign stop     = en_we && !wdata[0];

    owt_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start || stop || !st_q.running),
        .tick_in   (src_rise),
        .ratio_sel (st_q.div),
        .tick_out  (pre_tick)
    );

    always_comb begin
        target = CNT_W'(st_q.len) << UNIT_SHIFT;
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (ctrl_we) begin
            st_d.src = src_sel_e'(wdata[0]);
            st_d.div = wdata[DIV_W:1];
        end
        if (data_we) st_d.len = wdata;
        if (stop) begin
            st_d.en      = 1'b0;
            st_d.running = 1'b0;
            st_d.stable  = 1'b0;
            st_d.cnt     = '0;
        end else if (start) begin
            st_d.en      = 1'b1;
            st_d.running = 1'b1;
            st_d.stable  = 1'b0;
            st_d.cnt     = '0;
        end else if (st_q.running) begin
            if (st_q.cnt >= target) begin
                st_d.running = 1'b0;
                st_d.stable  = 1'b1;
                st_d.irq     = 1'b1;
            end else if (pre_tick) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign warm_irq   = st_q.irq;
    assign osc_stable = st_q.stable;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_irq |=> !warm_irq); // R6
    AST_IRQ_WITH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_stable) |-> warm_irq); // R6
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !wdata[0]) |=> (!osc_stable && st_q.cnt == '0)); // R8
    AST_REWRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata[0] && st_q.en && osc_stable) |=> (osc_stable && !warm_irq)); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (st_q.cnt == '0 && !osc_stable)); // R8
    AST_START_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata[0] && !st_q.en) |=> (st_q.cnt == '0 && !osc_stable)); // R2
endmodule

// File: tb/osc_warmup_timer_bench.sv
module osc_warmup_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT      = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hf_osc = 1'b0;
    logic       lf_osc = 1'b0;
    logic       ctrl_we = 1'b0;
    logic       data_we = 1'b0;
    logic       en_we = 1'b0;
    logic [7:0] wdata = '0;
    logic       warm_irq;
    logic       osc_stable;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;

    osc_warmup_timer #(.UNIT_SHIFT(SHIFT)) u_osc_warmup_timer (
        .clk(clk), .rst_n(rst_n), .hf_osc(hf_osc), .lf_osc(lf_osc),
        .ctrl_we(ctrl_we), .data_we(data_we), .en_we(en_we), .wdata(wdata),
        .warm_irq(warm_irq), .osc_stable(osc_stable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n && warm_irq) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [7:0] v);
        @(negedge clk);
        wdata = v;
        ctrl_we = (which == 0);
        data_we = (which == 1);
        en_we   = (which == 2);
        @(negedge clk);
        ctrl_we = 1'b0; data_we = 1'b0; en_we = 1'b0;
    endtask

    task automatic pulses(input bit slow, input int n);
        for (int i = 0; i < n; i++) begin
            if (slow) lf_osc = 1'b1; else hf_osc = 1'b1;
            repeat (3) @(negedge clk);
            if (slow) lf_osc = 1'b0; else hf_osc = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // expect completion exactly at edge count n
    task automatic run_count(input string req, input bit slow, input int n);
        int base;
        base = irq_seen;
        pulses(slow, n - 1);
        check({req, " stable before last edge"}, osc_stable, 0);
        pulses(slow, 1);
        check({req, " stable after last edge"}, osc_stable, 1);
        check({req, " one irq"}, irq_seen - base, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 stable", osc_stable, 0);
        check("R1 irq", warm_irq, 0);
        // reset control = fast source, /8; length 0 => enabling completes without edges
        wr(2, 8'h01);
        repeat (2) @(negedge clk);
        check("R1 length zero after reset", osc_stable, 1);
        wr(2, 8'h00);
    endtask

    task automatic t_fast_div2;
        wr(0, 8'b0000_0100);             // fast, div 2 (R4 code 10)
        wr(1, 8'd3);
        wr(2, 8'h01);                    // R2 start
        run_count("R5 fast div2", 1'b0, 2 * (3 << SHIFT));
        wr(2, 8'h00);
    endtask

    task automatic t_slow_div1;
        wr(0, 8'b0000_0111);             // slow, div 1 (R4 code 11)
        wr(1, 8'd2);
        wr(2, 8'h01);
        pulses(1'b0, 20);                // R3 unselected fast source ignored
        check("R3 fast ignored when slow selected", osc_stable, 0);
        run_count("R3 slow div1", 1'b1, 1 * (2 << SHIFT));
        wr(2, 8'h00);
    endtask

    task automatic t_div8;
        wr(0, 8'b0000_0000);             // fast, div 8 (R4 code 00)
        wr(1, 8'd1);
        wr(2, 8'h01);
        run_count("R4 div8", 1'b0, 8 * (1 << SHIFT));
        wr(2, 8'h00);
        wr(0, 8'b0000_0010);             // div 4 (R4 code 01)
        wr(2, 8'h01);
        run_count("R4 div4", 1'b0, 4 * (1 << SHIFT));
    endtask

    task automatic t_rewrite;
        int base;
        base = irq_seen;
        wr(2, 8'h01);                    // already enabled and stable
        repeat (3) @(negedge clk);
        check("R7 stable kept after rewrite", osc_stable, 1);
        check("R7 no irq after rewrite", irq_seen - base, 0);
        wr(2, 8'h00);
        wr(0, 8'b0000_0110);             // fast, div 1
        wr(1, 8'd2);
        wr(2, 8'h01);
        pulses(1'b0, 4);
        wr(2, 8'h01);                    // mid-count rewrite must not restart
        run_count("R7 mid-count rewrite", 1'b0, (2 << SHIFT) - 4);
    endtask

    task automatic t_abort;
        wr(2, 8'h00);
        repeat (2) @(negedge clk);
        check("R8 stable cleared", osc_stable, 0);
        wr(2, 8'h01);
        pulses(1'b0, 5);
        wr(2, 8'h00);                    // discard partial count
        wr(2, 8'h01);
        run_count("R8 full count after abort", 1'b0, 2 << SHIFT);
        wr(2, 8'h00);
    endtask

    task automatic t_zero_len;
        int base;
        wr(1, 8'd0);
        base = irq_seen;
        wr(2, 8'h01);
        check("R9 not yet stable", osc_stable, 0);
        @(negedge clk);
        check("R9 stable with zero length", osc_stable, 1);
        @(negedge clk);
        check("R6 single irq for zero length", irq_seen - base, 1);
        wr(2, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast_div2();
        t_slow_div1();
        t_div8();
        t_rewrite();
        t_abort();
        t_zero_len();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule